// File: doc/BRIEF.md
# Single-Precision Minimum / Maximum Selector

This combinational unit takes two single-precision floating-point words, `opnd_s` and `opnd_t`, and returns one of them unchanged. A 2-bit select picks one of four choices. The first two are the signed minimum and the signed maximum. The other two choose by absolute value: the operand with the smaller magnitude, or the one with the larger magnitude. The result is always a copy of one of the input words, so no rounding takes place and no new encodings are produced.

Ordering is worked out directly from the IEEE bit fields: the sign bit plus an unsigned compare of the exponent-and-mantissa bits. There is no floating-point subtractor. A NaN operand loses to a numeric one, and when both operands are NaN the first one is passed through. Positive zero and negative zero are equal for ordering. When two operands have equal magnitudes, both magnitude choices return the operand with the larger signed value.

The unit fits in an execute stage that needs a branch-free min/max in a single cycle. A NaN test, two comparators and a 2:1 word multiplexer form the whole path.

Top module: `fp_minmax_unit`

## Requirements
- R1: When both operands are NaN (exponent bits 30:23 all ones and mantissa bits 22:0 nonzero), the result equals `opnd_s` bit for bit, whatever the select.
- R2: When exactly one operand is NaN, the result equals the other operand, whatever the select.
- R3: Select 0 (signed minimum): the result is `opnd_t` when `opnd_s` >= `opnd_t` in signed value, otherwise `opnd_s`.
- R4: Select 1 (signed maximum): the result is `opnd_t` when `opnd_s` <= `opnd_t` in signed value, otherwise `opnd_s`.
- R5: Select 2 (minimum magnitude): the result is the operand whose absolute value is smaller.
- R6: Select 3 (maximum magnitude): the result is the operand whose absolute value is larger.
- R7: When the absolute values are equal, selects 2 and 3 both return the operand with the larger signed value, and return `opnd_t` when the signed values are also equal.
- R8: +0 (0x00000000) and -0 (0x80000000) compare as equal. For example, select 0 with `opnd_s`=+0 and `opnd_t`=-0 returns -0.
- R9: Infinities (exponent all ones, mantissa zero) order outside every finite value: +inf is above every finite value and -inf is below every finite value. Subnormals order by their value.
- R10: For every input, the result is bit-exactly equal to `opnd_s` or to `opnd_t`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | 0 signed min, 1 signed max, 2 min magnitude, 3 max magnitude |
| opnd_s | input | 32 | First operand, single-precision bit pattern |
| opnd_t | input | 32 | Second operand, single-precision bit pattern |
| result | output | 32 | Selected operand |

## Verification
Two functions can both apply to one input pair. The first pairing is the magnitude comparison and the tie rule, when the operands share a magnitude but differ in sign. The second is the NaN bypass and the numeric selection, when one operand is a NaN. The bench builds both cases on purpose: it flips only the sign bit of an operand, duplicates it exactly, pairs +0 with -0, and places quiet NaN patterns on either input. It judges each case against a behavioural model that converts the operands to real numbers and applies the rules above. The same check runs on random pairs whose exponents are drawn from a small set, so that ties and near-ties occur often.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    parameter int EXP_W = 8;
    parameter int MAN_W = 23;
    localparam int MAG_W  = EXP_W + MAN_W;
    localparam int WORD_W = 1 + MAG_W;

    typedef logic [WORD_W-1:0] fp_word_t;

    typedef enum logic [1:0] {
        SEL_MIN    = 2'd0,
        SEL_MAX    = 2'd1,
        SEL_MINMAG = 2'd2,
        SEL_MAXMAG = 2'd3
    } mm_op_e;

    // Decoded view of one operand
    typedef struct packed {
        logic             nan;
        logic             zero;
        logic             neg;
        logic [MAG_W-1:0] mag;
    } fp_view_t;

    // Relations of operand s against operand t
    typedef struct packed {
        logic s_lt;   // signed s < t
        logic s_gt;   // signed s > t
        logic m_lt;   // |s| < |t|
        logic m_gt;   // |s| > |t|
    } fp_rel_t;

    function automatic fp_view_t view_of(input fp_word_t w);
        fp_view_t v;
        logic [EXP_W-1:0] e;
        logic [MAN_W-1:0] m;
        e      = w[MAG_W-1:MAN_W];
        m      = w[MAN_W-1:0];
        v.neg  = w[WORD_W-1];
        v.mag  = w[MAG_W-1:0];
        v.nan  = (&e) && (|m);
        v.zero = ~(|w[MAG_W-1:0]);
        return v;
    endfunction

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
(
    input  fp_word_t word_in,
    output fp_view_t view_out
);
    always_comb view_out = view_of(word_in);
endmodule

// File: rtl/fpmm_order.sv
module fpmm_order
    import fpmm_pkg::*;
(
    input  fp_view_t a_view,
    input  fp_view_t b_view,
    output fp_rel_t  rel
);
    logic mag_lt, mag_gt, both_zero;

    always_comb begin
        mag_lt    = a_view.mag < b_view.mag;
        mag_gt    = a_view.mag > b_view.mag;
        both_zero = a_view.zero && b_view.zero;

        rel.m_lt = mag_lt;
        rel.m_gt = mag_gt;

        if (both_zero) begin
            rel.s_lt = 1'b0;
            rel.s_gt = 1'b0;
        end else if (a_view.neg != b_view.neg) begin
            rel.s_lt = a_view.neg;
            rel.s_gt = b_view.neg;
        end else if (!a_view.neg) begin
            rel.s_lt = mag_lt;
            rel.s_gt = mag_gt;
        end else begin
            rel.s_lt = mag_gt;
            rel.s_gt = mag_lt;
        end
    end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
    import fpmm_pkg::*;
(
    input  mm_op_e   op,
    input  logic     nan_s,
    input  logic     nan_t,
    input  fp_rel_t  rel,
    input  fp_word_t word_s,
    input  fp_word_t word_t,
    output fp_word_t word_out
);
    logic take_s;
    logic tie_s;

    always_comb begin
        tie_s = !rel.m_lt && !rel.m_gt && rel.s_gt;
        if (nan_s && nan_t)  take_s = 1'b1;
        else if (nan_s)      take_s = 1'b0;
        else if (nan_t)      take_s = 1'b1;
        else begin
            unique case (op)
                SEL_MIN:    take_s = rel.s_lt;
                SEL_MAX:    take_s = rel.s_gt;
                SEL_MINMAG: take_s = rel.m_lt || tie_s;
                SEL_MAXMAG: take_s = rel.m_gt || tie_s;
                default:    take_s = 1'b0;
            endcase
        end
        word_out = take_s ? word_s : word_t;
    end
endmodule

// File: rtl/fp_minmax_unit.sv
module fp_minmax_unit
    import fpmm_pkg::*;
(
    input  logic [1:0]        op_sel,
    input  logic [WORD_W-1:0] opnd_s,
    input  logic [WORD_W-1:0] opnd_t,
    output logic [WORD_W-1:0] result
);
    localparam int N_OPND = 2;

    fp_word_t words [N_OPND];
    fp_view_t views [N_OPND];
    fp_rel_t  rel_st;
    mm_op_e   op_dec;

    assign words[0] = opnd_s;
    assign words[1] = opnd_t;
    assign op_dec   = mm_op_e'(op_sel);

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
        fpmm_classify u_cls (
            .word_in  (words[gi]),
            .view_out (views[gi])
        );
    end

    fpmm_order u_order (
        .a_view (views[0]),
        .b_view (views[1]),
        .rel    (rel_st)
    );

    fpmm_select u_sel (
        .op       (op_dec),
        .nan_s    (views[0].nan),
        .nan_t    (views[1].nan),
        .rel      (rel_st),
        .word_s   (opnd_s),
        .word_t   (opnd_t),
        .word_out (result)
    );
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker
    import fpmm_pkg::*;
(
    input logic [1:0]        op_sel,
    input logic [WORD_W-1:0] opnd_s,
    input logic [WORD_W-1:0] opnd_t,
    input logic [WORD_W-1:0] result
);
    // Order key: an unsigned integer that rises with the signed value; both zeros share one key
    function automatic logic [WORD_W-1:0] okey(input logic [WORD_W-1:0] w);
        if (w[MAG_W-1:0] == '0) return {1'b1, {MAG_W{1'b0}}};
        if (w[WORD_W-1])        return {1'b0, ~w[MAG_W-1:0]};
        return {1'b1, w[MAG_W-1:0]};
    endfunction

    function automatic logic is_nan(input logic [WORD_W-1:0] w);
        return (w[MAG_W-1:MAN_W] == {EXP_W{1'b1}}) && (w[MAN_W-1:0] != '0);
    endfunction

    logic ns, nt, num;
    always_comb begin
        ns  = is_nan(opnd_s);
        nt  = is_nan(opnd_t);
        num = !ns && !nt;

        p_result_is_operand_r10: assert (result == opnd_s || result == opnd_t)
            else $error("result is neither operand");
        if (ns && nt)
            p_both_nan_first_r1: assert (result == opnd_s) else $error("both NaN");
        if (ns != nt)
            p_nan_skipped_r2: assert (!is_nan(result)) else $error("NaN chosen over number");
        if (num && op_sel == 2'd0)
            p_min_lowest_r3: assert (okey(result) <= okey(opnd_s) && okey(result) <= okey(opnd_t))
                else $error("min not lowest");
        if (num && op_sel == 2'd1)
            p_max_highest_r4: assert (okey(result) >= okey(opnd_s) && okey(result) >= okey(opnd_t))
                else $error("max not highest");
        if (num && op_sel == 2'd2)
            p_minmag_smallest_r5: assert (result[MAG_W-1:0] <= opnd_s[MAG_W-1:0]
                                          && result[MAG_W-1:0] <= opnd_t[MAG_W-1:0])
                else $error("min magnitude wrong");
        if (num && op_sel == 2'd3)
            p_maxmag_largest_r6: assert (result[MAG_W-1:0] >= opnd_s[MAG_W-1:0]
                                         && result[MAG_W-1:0] >= opnd_t[MAG_W-1:0])
                else $error("max magnitude wrong");
        if (num && op_sel[1] && opnd_s[MAG_W-1:0] == opnd_t[MAG_W-1:0])
            p_tie_upper_r7: assert (okey(result) >= okey(opnd_s) && okey(result) >= okey(opnd_t))
                else $error("tie not resolved upward");
    end
endmodule

bind fp_minmax_unit fpmm_checker u_fpmm_checker (
    .op_sel (op_sel),
    .opnd_s (opnd_s),
    .opnd_t (opnd_t),
    .result (result)
);

// File: tb/fp_minmax_unit_test.sv
module fp_minmax_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  op_sel = 2'd0;
    logic [31:0] opnd_s = 32'd0;
    logic [31:0] opnd_t = 32'd0;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fp_minmax_unit uut (
        .op_sel (op_sel),
        .opnd_s (opnd_s),
        .opnd_t (opnd_t),
        .result (result)
    );

    function automatic bit nan_of(input logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    function automatic real val_of(input logic [31:0] w);
        real v;
        int  e;
        e = int'(w[30:23]);
        if (e == 255)    v = $bitstoreal(64'h7FF0000000000000);
        else if (e == 0) v = real'(w[22:0]) * (2.0 ** (-149));
        else             v = (1.0 + real'(w[22:0]) / 8388608.0) * (2.0 ** (e - 127));
        return w[31] ? -v : v;
    endfunction

    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        real ra, rb, ma, mb;
        if (nan_of(a) && nan_of(b)) return a;
        if (nan_of(a)) return b;
        if (nan_of(b)) return a;
        ra = val_of(a); rb = val_of(b);
        ma = (ra < 0.0) ? -ra : ra;
        mb = (rb < 0.0) ? -rb : rb;
        case (op)
            2'd0: return (ra >= rb) ? b : a;
            2'd1: return (ra <= rb) ? b : a;
            2'd2: if (ma > mb) return b; else if (ma < mb) return a; else return (ra > rb) ? a : b;
            default: if (ma < mb) return b; else if (ma > mb) return a; else return (ra > rb) ? a : b;
        endcase
    endfunction

    function automatic string tag_of(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        if (nan_of(a) && nan_of(b)) return "R1";
        if (nan_of(a) || nan_of(b)) return "R2";
        case (op)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] exp_v;
        @(posedge clk);
        op_sel <= op; opnd_s <= a; opnd_t <= b;
        @(negedge clk);
        exp_v = model(op, a, b);
        n_checks++;
        if (result !== exp_v) begin
            n_fails++;
            $display("FAIL %s op=%0d s=%h t=%h got %h expected %h", tag, op, a, b, result, exp_v);
        end
        n_checks++;   // R10: output is one of the inputs
        if (result !== a && result !== b) begin
            n_fails++;
            $display("FAIL R10 op=%0d s=%h t=%h got %h expected s or t", op, a, b, result);
        end
    endtask

    function automatic logic [31:0] rand_word();
        logic [7:0] exps [6] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFE, 8'hFF};
        logic [31:0] r;
        r = $urandom;
        r[30:23] = exps[$urandom % 6];
        if ($urandom % 4 == 0) r[22:0] = r[22:0] & 23'h7;
        return r;
    endfunction

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_checks++;   // reset state: zero operands give zero
        if (result !== 32'd0) begin
            n_fails++;
            $display("FAIL R3 reset got %h expected 00000000", result);
        end
        rst <= 1'b0;

        for (int op = 0; op < 4; op++) begin
            apply(op[1:0], 32'h7FC00001, 32'h7FC00002, "R1");   // both NaN
            apply(op[1:0], 32'hFFC00000, 32'h3F800000, "R2");   // NaN s
            apply(op[1:0], 32'hC0000000, 32'h7F800001, "R2");   // NaN t
            apply(op[1:0], 32'h3F800000, 32'h40000000, tag_of(op[1:0], 0, 0));
            apply(op[1:0], 32'hC0400000, 32'h3F000000, tag_of(op[1:0], 0, 0));
            apply(op[1:0], 32'h3F800000, 32'hBF800000, "R7");   // +1 / -1
            apply(op[1:0], 32'hBF800000, 32'h3F800000, "R7");
            apply(op[1:0], 32'h40490FDB, 32'h40490FDB, "R7");   // identical
            apply(op[1:0], 32'h00000000, 32'h80000000, "R8");
            apply(op[1:0], 32'h80000000, 32'h00000000, "R8");
            apply(op[1:0], 32'h7F800000, 32'h7F7FFFFF, "R9");
            apply(op[1:0], 32'hFF800000, 32'hFF7FFFFF, "R9");
            apply(op[1:0], 32'h00000001, 32'h80000002, "R9");   // subnormals
            apply(op[1:0], 32'h7F800000, 32'hFF800000, "R9");
        end

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            logic [1:0]  op;
            a  = rand_word();
            b  = rand_word();
            op = 2'($urandom);
            case ($urandom % 4)
                0: b = {~a[31], a[30:0]};
                1: b = a;
                default: ;
            endcase
            apply(op, a, b, (a[30:0] == b[30:0] && op[1] && !nan_of(a)) ? "R7" : tag_of(op, a, b));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule